// File: doc/BRIEF.md
# Multi-depth pixel line unpacker

This block turns a stream of 32-bit frame-buffer words into a stream of pixels for one scan line, one pixel per handshake. A pixel is either a palette index (1, 2, 4 or 8 bits deep) or a direct colour that is widened to 8-bit red, green and blue. The direct formats are 16-bit 5551, 16-bit 565, 12-bit 444 held in a 16-bit slot, and 24-bit colour in a 32-bit slot. Three ways of laying pixels into a word are supported, and a swap bit chooses which end of a direct-colour pixel holds red.

A 3-bit depth code, three ordering/swap bits, a 2-bit external mux select and a column count configure a line; they must be held steady while a line is in flight. The block also reports the number of source bytes the line occupies so that a fetch engine can size its reads. Memory fetch and palette lookup sit outside. A parameter picks one of two variants: the plain one lets the external mux reinterpret the native 16-bit depth; the extended one fixes that depth to 5551.

Top module: `pixel_line_unpacker`

## Requirements
- R1: Depth codes 0, 1, 2 and 3 give palette indices of 1, 2, 4 and 8 bits; such a pixel drives out_is_index high, out_index with the field zero-extended, and out_r/out_g/out_b at zero.
- R2: line_bytes equals line_cols shifted right by 3, 2 and 1 for codes 0, 1, 2; equals line_cols for code 3; line_cols times 2 for codes 4, 6 and 7; line_cols times 4 for code 5.
- R3: With be_bytes and be_pixels both low, pixel k of a word of b-bit pixels is word bits [k*b +: b].
- R4: With be_bytes high (whatever be_pixels is), the word is byte-reversed and pixels are taken from the most significant end: pixel 0 starts at the top bit of byte 0 and a 16-bit pixel is {byte0, byte1}.
- R5: With be_bytes low and be_pixels high, bytes are taken in ascending order but pixels narrower than 8 bits fill each byte from its top bit down; 8-bit and wider pixels behave as in R3.
- R6: A direct-colour pixel has a low field, a middle field (green) and a high field; with the effective swap bit low the low field is red and the high field is blue, with it high the two are exchanged.
- R7: 5551 uses bits [4:0], [9:5], [14:10], ignores bit 15, and widens each 5-bit field by appending three zero bits.
- R8: 565 uses bits [4:0], [10:5], [15:11] (green widened by two zero bits); code 7 (444) uses bits [3:0], [7:4], [11:8] widened by repeating the nibble; code 5 uses bytes 0, 1, 2 of the pixel and ignores byte 3.
- R9: In the plain variant, code 4 with mux select 1 is 5551, with select 3 is 565 with the swap forced high, with selects 0 and 2 is 565 honouring bgr_sel; no other code depends on the mux select.
- R10: In the extended variant, code 4 is 5551 whatever the mux select; code 6 is 565.
- R11: Exactly line_cols pixels are emitted per line, the last with out_last high; line_done pulses for one cycle in the cycle after the last pixel is accepted; the unused rest of the current word is dropped and the next line starts from a fresh word.
- R12: While out_valid is high and out_ready low, the pixel is held and in_ready is low; a new word is taken in the same cycle that the last pixel of the current word (or line) is accepted, so one pixel per cycle is sustained.
- R13: After reset out_valid and line_done are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_code | input | 3 | Pixel depth/format code |
| bgr_sel | input | 1 | Swap red and blue fields |
| be_bytes | input | 1 | Big-endian bytes and pixels (priority) |
| be_pixels | input | 1 | Little-endian bytes, big-endian pixels |
| mux_sel | input | 2 | External 16-bit format select (plain variant) |
| line_cols | input | COLS_W | Pixels per line (at least 1) |
| line_bytes | output | COLS_W+2 | Source bytes per line |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel consumer ready |
| out_last | output | 1 | Pixel is the last of the line |
| out_is_index | output | 1 | Pixel is a palette index |
| out_index | output | 8 | Palette index |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| line_done | output | 1 | One-cycle pulse after a line completes |

## Verification
A wrong pixel counter or bit-position calculation shows up at the ports on the very next accepted pixel as a wrong index or colour, so each vector checks the last pixel of a line whose length places that pixel deep inside the word. A wrong column counter shows up as a pixel count that differs from line_cols, a missing or early line_done, or a next line that starts mid-word, all visible within one line. Handshake faults show as a pixel that changes while stalled or as lost throughput, measured as the cycles a multi-word line takes.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        FMT_IDX  = 3'd0,
        FMT_5551 = 3'd1,
        FMT_565  = 3'd2,
        FMT_444  = 3'd3,
        FMT_888  = 3'd4
    } pix_fmt_e;

    typedef enum logic [1:0] {
        ORD_LE_LE = 2'd0,
        ORD_BE_BE = 2'd1,
        ORD_LE_BE = 2'd2
    } pix_ord_e;

    typedef struct packed {
        pix_fmt_e   fmt;
        logic [2:0] lg;     // log2 of bits per pixel slot
        logic       swap;   // effective red/blue swap
    } mode_s;

    typedef struct packed {
        logic       is_index;
        logic [7:0] index;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } pix_s;

    function automatic pix_ord_e order_of(input logic be_b, input logic be_p);
        if (be_b)      return ORD_BE_BE;
        else if (be_p) return ORD_LE_BE;
        else           return ORD_LE_LE;
    endfunction

    // highest pixel number inside one word
    function automatic logic [4:0] last_slot(input logic [2:0] lg);
        return 5'(5'd31 >> lg);
    endfunction

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [7:0] widen5(input logic [4:0] f);
        return {f, 3'b000};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] f);
        return {f, 2'b00};
    endfunction

    function automatic logic [7:0] widen4(input logic [3:0] f);
        return {f, f};
    endfunction

endpackage

// File: rtl/pxu_mode_decode.sv
module pxu_mode_decode
    import pxu_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic [2:0] depth_code,
    input  logic       bgr_sel,
    input  logic [1:0] mux_sel,
    output mode_s      mode
);

    pix_fmt_e native_fmt;
    logic     native_swap;

    generate
        if (EXTENDED) begin : g_ext
            // R10: native 16-bit depth is always 5551
            assign native_fmt  = FMT_5551;
            assign native_swap = bgr_sel;
        end else begin : g_plain
            // R9: external select reinterprets the native 16-bit depth
            always_comb begin
                native_fmt  = FMT_565;
                native_swap = bgr_sel;
                case (mux_sel)
                    2'd1: native_fmt = FMT_5551;
                    2'd3: native_swap = 1'b1;
                    default: ;
                endcase
            end
        end
    endgenerate

    always_comb begin
        mode.fmt  = FMT_IDX;
        mode.lg   = depth_code;
        mode.swap = bgr_sel;
        case (depth_code)
            3'd4: begin
                mode.fmt  = native_fmt;
                mode.lg   = 3'd4;
                mode.swap = native_swap;
            end
            3'd5: begin
                mode.fmt = FMT_888;
                mode.lg  = 3'd5;
            end
            3'd6: begin
                mode.fmt = FMT_565;
                mode.lg  = 3'd4;
            end
            3'd7: begin
                mode.fmt = FMT_444;
                mode.lg  = 3'd4;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pxu_word_walker.sv
module pxu_word_walker
    import pxu_pkg::*;
#(
    parameter int COLS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        lg,
    input  logic [COLS_W-1:0] line_cols,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last,
    output logic              line_done,
    output logic [WORD_W-1:0] cur_word,
    output logic [4:0]        cur_slot
);

    logic              have_word;
    logic [WORD_W-1:0] word_q;
    logic [4:0]        slot_q;
    logic [COLS_W-1:0] col_q;
    logic              done_q;

    logic       out_fire;
    logic       word_end;
    logic       line_end;
    logic       take;
    logic [4:0] slot_max;

    assign slot_max = last_slot(lg);
    assign word_end = (slot_q == slot_max);
    assign line_end = (col_q == line_cols - COLS_W'(1));
    assign out_fire = have_word & out_ready;
    assign in_ready = ~have_word | (out_fire & (word_end | line_end));
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_word <= 1'b0;
            word_q    <= '0;
            slot_q    <= '0;
            col_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= out_fire & line_end;
            if (out_fire) begin
                if (line_end) begin
                    col_q  <= '0;
                    slot_q <= '0;
                end else begin
                    col_q  <= col_q + COLS_W'(1);
                    slot_q <= word_end ? 5'd0 : slot_q + 5'd1;
                end
            end
            if (take) begin
                have_word <= 1'b1;
                word_q    <= in_word;
            end else if (out_fire & (word_end | line_end)) begin
                have_word <= 1'b0;
            end
        end
    end

    assign out_valid = have_word;
    assign out_last  = line_end;
    assign line_done = done_q;
    assign cur_word  = word_q;
    assign cur_slot  = slot_q;

    // R12
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (have_word && !out_ready) |=> (have_word && $stable(word_q) && $stable(slot_q)));

    // R11
    col_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        have_word |-> (col_q < line_cols));

    // R3
    slot_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        have_word |-> (slot_q <= slot_max));

endmodule

// File: rtl/pxu_pixel_extract.sv
module pxu_pixel_extract
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [4:0]        slot,
    input  logic [2:0]        lg,
    input  pix_ord_e          order,
    output logic [23:0]       raw
);

    logic [WORD_W-1:0] src;
    logic [5:0]        bw;
    logic [5:0]        lin;
    logic [5:0]        pos;
    logic [WORD_W-1:0] mask;

    always_comb begin
        bw   = 6'd1 << lg;
        lin  = {1'b0, slot} << lg;
        src  = (order == ORD_BE_BE) ? swap_bytes(word) : word;
        mask = (lg >= 3'd5) ? '1 : ((32'd1 << bw) - 32'd1);
        case (order)
            // R4: most significant end first after byte reversal
            ORD_BE_BE: pos = 6'd32 - lin - bw;
            // R5: bytes ascending, sub-byte pixels from the top bit down
            ORD_LE_BE: begin
                if (lg < 3'd3)
                    pos = {lin[5:3], 3'b000} + (6'd8 - bw - {3'b000, lin[2:0]});
                else
                    pos = lin;
            end
            // R3
            default:   pos = lin;
        endcase
        raw = 24'((src >> pos) & mask);
    end

endmodule

// File: rtl/pxu_color_expand.sv
module pxu_color_expand
    import pxu_pkg::*;
(
    input  logic [23:0] raw,
    input  mode_s       mode,
    output pix_s        pix
);

    logic [7:0] lo_f;
    logic [7:0] mid_f;
    logic [7:0] hi_f;

    always_comb begin
        lo_f  = '0;
        mid_f = '0;
        hi_f  = '0;
        case (mode.fmt)
            FMT_5551: begin
                lo_f  = widen5(raw[4:0]);
                mid_f = widen5(raw[9:5]);
                hi_f  = widen5(raw[14:10]);
            end
            FMT_565: begin
                lo_f  = widen5(raw[4:0]);
                mid_f = widen6(raw[10:5]);
                hi_f  = widen5(raw[15:11]);
            end
            FMT_444: begin
                lo_f  = widen4(raw[3:0]);
                mid_f = widen4(raw[7:4]);
                hi_f  = widen4(raw[11:8]);
            end
            FMT_888: begin
                lo_f  = raw[7:0];
                mid_f = raw[15:8];
                hi_f  = raw[23:16];
            end
            default: ;
        endcase

        pix.is_index = (mode.fmt == FMT_IDX);
        pix.index    = pix.is_index ? raw[7:0] : 8'd0;
        pix.g        = mid_f;
        // R6
        pix.r        = mode.swap ? hi_f : lo_f;
        pix.b        = mode.swap ? lo_f : hi_f;
    end

endmodule

// File: rtl/pixel_line_unpacker.sv
module pixel_line_unpacker
    import pxu_pkg::*;
#(
    parameter int COLS_W   = 12,
    parameter bit EXTENDED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        depth_code,
    input  logic              bgr_sel,
    input  logic              be_bytes,
    input  logic              be_pixels,
    input  logic [1:0]        mux_sel,
    input  logic [COLS_W-1:0] line_cols,
    output logic [COLS_W+1:0] line_bytes,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last,
    output logic              out_is_index,
    output logic [7:0]        out_index,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b,
    output logic              line_done
);

    localparam int LB_W = COLS_W + 2;

    mode_s             mode;
    pix_ord_e          order;
    logic [WORD_W-1:0] cur_word;
    logic [4:0]        cur_slot;
    logic [23:0]       raw;
    pix_s              pix;
    logic [LB_W-1:0]   cols_x;

    assign order  = order_of(be_bytes, be_pixels);
    assign cols_x = LB_W'(line_cols);

    // R2: bytes per line follow the depth code
    always_comb begin
        case (depth_code)
            3'd0:    line_bytes = cols_x >> 3;
            3'd1:    line_bytes = cols_x >> 2;
            3'd2:    line_bytes = cols_x >> 1;
            3'd3:    line_bytes = cols_x;
            3'd5:    line_bytes = cols_x << 2;
            default: line_bytes = cols_x << 1;
        endcase
    end

    pxu_mode_decode #(.EXTENDED(EXTENDED)) u_mode (
        .depth_code (depth_code),
        .bgr_sel    (bgr_sel),
        .mux_sel    (mux_sel),
        .mode       (mode)
    );

    pxu_word_walker #(.COLS_W(COLS_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .lg        (mode.lg),
        .line_cols (line_cols),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .line_done (line_done),
        .cur_word  (cur_word),
        .cur_slot  (cur_slot)
    );

    pxu_pixel_extract u_extract (
        .word  (cur_word),
        .slot  (cur_slot),
        .lg    (mode.lg),
        .order (order),
        .raw   (raw)
    );

    pxu_color_expand u_color (
        .raw  (raw),
        .mode (mode),
        .pix  (pix)
    );

    assign out_is_index = pix.is_index;
    assign out_index    = pix.index;
    assign out_r        = pix.r;
    assign out_g        = pix.g;
    assign out_b        = pix.b;

    // R1
    index_no_color_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_index) |-> ((out_r | out_g | out_b) == 8'd0));

    // R12
    no_take_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R11
    done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> line_done);

endmodule

// File: tb/pixel_line_unpacker_bench.sv
`timescale 1ns/1ps
module pixel_line_unpacker_bench;

    localparam int COLS_W = 12;
    localparam int NVEC   = 21;

    typedef struct packed {
        logic [2:0]  d;
        logic        bgr;
        logic        bb;
        logic        bp;
        logic [1:0]  mux;
        logic [11:0] cols;
        logic [31:0] w;
        logic        isi;
        logic [7:0]  idx;
        logic [7:0]  r;
        logic [7:0]  g;
        logic [7:0]  b;
        logic [3:0]  req;
    } vec_t;

    // last pixel of a line is checked; word bytes are 71 8E A5 C3 (byte0 first)
    localparam vec_t VECS [NVEC] = '{
        '{3'd0,1'b0,1'b0,1'b0,2'd0,12'd5,32'hC3A58E71,1'b1,8'd1,8'h00,8'h00,8'h00,4'd3},   // R3
        '{3'd0,1'b0,1'b0,1'b1,2'd0,12'd2,32'hC3A58E71,1'b1,8'd1,8'h00,8'h00,8'h00,4'd5},   // R5
        '{3'd0,1'b0,1'b1,1'b1,2'd0,12'd9,32'hC3A58E71,1'b1,8'd1,8'h00,8'h00,8'h00,4'd4},   // R4
        '{3'd1,1'b0,1'b0,1'b0,2'd0,12'd3,32'hC3A58E71,1'b1,8'd3,8'h00,8'h00,8'h00,4'd1},   // R1
        '{3'd1,1'b0,1'b0,1'b1,2'd0,12'd1,32'hC3A58E71,1'b1,8'd1,8'h00,8'h00,8'h00,4'd5},   // R5
        '{3'd2,1'b0,1'b0,1'b0,2'd0,12'd4,32'hC3A58E71,1'b1,8'd8,8'h00,8'h00,8'h00,4'd3},   // R3
        '{3'd2,1'b0,1'b0,1'b1,2'd0,12'd4,32'hC3A58E71,1'b1,8'd14,8'h00,8'h00,8'h00,4'd5},  // R5
        '{3'd2,1'b0,1'b1,1'b0,2'd0,12'd2,32'hC3A58E71,1'b1,8'd1,8'h00,8'h00,8'h00,4'd4},   // R4
        '{3'd3,1'b0,1'b0,1'b0,2'd0,12'd3,32'hC3A58E71,1'b1,8'hA5,8'h00,8'h00,8'h00,4'd1},  // R1
        '{3'd3,1'b0,1'b1,1'b0,2'd0,12'd4,32'hC3A58E71,1'b1,8'hC3,8'h00,8'h00,8'h00,4'd4},  // R4
        '{3'd5,1'b0,1'b0,1'b0,2'd0,12'd1,32'hC3A58E71,1'b0,8'd0,8'h71,8'h8E,8'hA5,4'd8},   // R8
        '{3'd5,1'b1,1'b0,1'b0,2'd0,12'd1,32'hC3A58E71,1'b0,8'd0,8'hA5,8'h8E,8'h71,4'd6},   // R6
        '{3'd5,1'b0,1'b1,1'b0,2'd0,12'd1,32'hC3A58E71,1'b0,8'd0,8'hC3,8'hA5,8'h8E,4'd4},   // R4
        '{3'd4,1'b0,1'b0,1'b0,2'd1,12'd1,32'hC3A58E71,1'b0,8'd0,8'h88,8'h98,8'h18,4'd7},   // R7
        '{3'd4,1'b1,1'b0,1'b0,2'd1,12'd1,32'hC3A58E71,1'b0,8'd0,8'h18,8'h98,8'h88,4'd6},   // R6
        '{3'd4,1'b0,1'b0,1'b0,2'd0,12'd2,32'hC3A58E71,1'b0,8'd0,8'h28,8'h74,8'hC0,4'd9},   // R9
        '{3'd4,1'b1,1'b0,1'b0,2'd2,12'd2,32'hC3A58E71,1'b0,8'd0,8'hC0,8'h74,8'h28,4'd9},   // R9
        '{3'd4,1'b0,1'b0,1'b0,2'd3,12'd2,32'hC3A58E71,1'b0,8'd0,8'hC0,8'h74,8'h28,4'd9},   // R9
        '{3'd6,1'b0,1'b0,1'b0,2'd1,12'd2,32'hC3A58E71,1'b0,8'd0,8'h28,8'h74,8'hC0,4'd9},   // R9 R8
        '{3'd7,1'b0,1'b0,1'b0,2'd0,12'd2,32'hC3A58E71,1'b0,8'd0,8'h55,8'hAA,8'h33,4'd8},   // R8
        '{3'd4,1'b0,1'b1,1'b0,2'd1,12'd1,32'hC3A58E71,1'b0,8'd0,8'h70,8'h60,8'hE0,4'd7}    // R7 R4
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        depth_code = '0;
    logic              bgr_sel = 1'b0;
    logic              be_bytes = 1'b0;
    logic              be_pixels = 1'b0;
    logic [1:0]        mux_sel = '0;
    logic [COLS_W-1:0] line_cols = 12'd1;
    logic [COLS_W+1:0] line_bytes, line_bytes_x;
    logic              in_valid = 1'b0;
    logic              in_ready, in_ready_x;
    logic [31:0]       in_word = '0;
    logic              out_valid, out_valid_x;
    logic              out_ready = 1'b0;
    logic              out_last, out_last_x;
    logic              out_is_index, out_is_index_x;
    logic [7:0]        out_index, out_index_x;
    logic [7:0]        out_r, out_g, out_b, out_r_x, out_g_x, out_b_x;
    logic              line_done, line_done_x;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    pixel_line_unpacker #(.COLS_W(COLS_W), .EXTENDED(1'b0)) u_pixel_line_unpacker (
        .clk(clk), .rst(rst), .depth_code(depth_code), .bgr_sel(bgr_sel),
        .be_bytes(be_bytes), .be_pixels(be_pixels), .mux_sel(mux_sel),
        .line_cols(line_cols), .line_bytes(line_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .out_is_index(out_is_index), .out_index(out_index),
        .out_r(out_r), .out_g(out_g), .out_b(out_b), .line_done(line_done)
    );

    pixel_line_unpacker #(.COLS_W(COLS_W), .EXTENDED(1'b1)) u_pixel_line_unpacker_ext (
        .clk(clk), .rst(rst), .depth_code(depth_code), .bgr_sel(bgr_sel),
        .be_bytes(be_bytes), .be_pixels(be_pixels), .mux_sel(mux_sel),
        .line_cols(line_cols), .line_bytes(line_bytes_x),
        .in_valid(in_valid), .in_ready(in_ready_x), .in_word(in_word),
        .out_valid(out_valid_x), .out_ready(out_ready), .out_last(out_last_x),
        .out_is_index(out_is_index_x), .out_index(out_index_x),
        .out_r(out_r_x), .out_g(out_g_x), .out_b(out_b_x), .line_done(line_done_x)
    );

    // captured by run_line
    logic [31:0] wq [0:7];
    int          got_px, used_w, line_cyc;
    logic        lp_isi, lp_last, ld_after;
    logic [7:0]  lp_idx, lp_r, lp_g, lp_b, lx_r, lx_g, lx_b;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_line(input int n, input int nw);
        int wi  = 0;
        int cyc = 0;
        logic fi, fo;
        got_px = 0;
        while (got_px < n && cyc < 2000) begin
            @(negedge clk);
            in_valid  = (wi < nw);
            in_word   = (wi < nw) ? wq[wi] : 32'h0;
            out_ready = 1'b1;
            #1;
            fi = in_valid & in_ready;
            fo = out_valid & out_ready;
            if (fo) begin
                got_px++;
                lp_isi = out_is_index; lp_idx = out_index; lp_last = out_last;
                lp_r = out_r; lp_g = out_g; lp_b = out_b;
                lx_r = out_r_x; lx_g = out_g_x; lx_b = out_b_x;
            end
            @(posedge clk);
            if (fi) wi++;
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        #1;
        ld_after = line_done;
        used_w   = wi;
        line_cyc = cyc;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R13 reset state
        check("R13", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R13", "in_ready", {31'd0, in_ready}, 32'd1);
        check("R13", "line_done", {31'd0, line_done}, 32'd0);

        // table walk: last pixel of a one-word line
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            depth_code = VECS[i].d; bgr_sel = VECS[i].bgr;
            be_bytes = VECS[i].bb; be_pixels = VECS[i].bp;
            mux_sel = VECS[i].mux; line_cols = VECS[i].cols;
            wq[0] = VECS[i].w;
            run_line(int'(VECS[i].cols), 1);
            check($sformatf("R%0d", VECS[i].req), "is_index", {31'd0, lp_isi}, {31'd0, VECS[i].isi});
            if (VECS[i].isi) begin
                check($sformatf("R%0d", VECS[i].req), "index", {24'd0, lp_idx}, {24'd0, VECS[i].idx});
                check("R1", "rgb zero", {8'd0, lp_r, lp_g, lp_b}, 32'd0);
            end else begin
                check($sformatf("R%0d", VECS[i].req), "rgb", {8'd0, lp_r, lp_g, lp_b},
                      {8'd0, VECS[i].r, VECS[i].g, VECS[i].b});
            end
        end

        // R2 bytes per line for 640 columns
        @(negedge clk);
        line_cols = 12'd640;
        for (int c = 0; c < 8; c++) begin
            int exp_b;
            depth_code = 3'(c);
            case (c)
                0: exp_b = 80;   1: exp_b = 160;  2: exp_b = 320; 3: exp_b = 640;
                5: exp_b = 2560; default: exp_b = 1280;
            endcase
            #1;
            check("R2", $sformatf("line_bytes code %0d", c), 32'(line_bytes), 32'(exp_b));
        end

        // R11 multi-word line, remainder dropped, next line from a fresh word
        @(negedge clk);
        depth_code = 3'd3; bgr_sel = 0; be_bytes = 0; be_pixels = 0; line_cols = 12'd6;
        wq[0] = 32'h04030201; wq[1] = 32'h08070605; wq[2] = 32'h0C0B0A09;
        run_line(6, 3);
        check("R11", "pixel count", 32'(got_px), 32'd6);
        check("R11", "last index", {24'd0, lp_idx}, 32'h06);
        check("R11", "out_last", {31'd0, lp_last}, 32'd1);
        check("R11", "line_done pulse", {31'd0, ld_after}, 32'd1);
        check("R12", "word taken with last pixel", 32'(used_w), 32'd3);
        @(negedge clk);
        #1;
        check("R11", "line_done one cycle", {31'd0, line_done}, 32'd0);
        line_cols = 12'd1;
        run_line(1, 0);
        check("R11", "next line fresh word", {24'd0, lp_idx}, 32'h09);

        // R12 stall holds the pixel and blocks input
        @(negedge clk);
        line_cols = 12'd2;
        in_valid = 1'b1; in_word = 32'h0000BBAA; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_word = 32'h11111111;
        repeat (3) @(negedge clk);
        #1;
        check("R12", "held valid", {31'd0, out_valid}, 32'd1);
        check("R12", "held index", {24'd0, out_index}, 32'hAA);
        check("R12", "in_ready low while stalled", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        check("R12", "second pixel after release", {24'd0, out_index}, 32'hBB);
        @(negedge clk);
        out_ready = 1'b0;

        // R12 throughput: three 32-bit pixels from three words
        @(negedge clk);
        depth_code = 3'd5; line_cols = 12'd3;
        wq[0] = 32'h1; wq[1] = 32'h2; wq[2] = 32'h00030303;
        run_line(3, 3);
        check("R12", "cycles for 3 pixels", 32'(line_cyc), 32'd4);
        check("R8", "third 32-bit pixel", {8'd0, lp_r, lp_g, lp_b}, 32'h030303);

        // R10 extended variant ignores the mux select for code 4
        @(negedge clk);
        depth_code = 3'd4; mux_sel = 2'd0; bgr_sel = 0; line_cols = 12'd2;
        wq[0] = 32'hC3A58E71;
        run_line(2, 1);
        check("R10", "extended 5551", {8'd0, lx_r, lx_g, lx_b}, 32'h28E880);
        check("R9", "plain 565", {8'd0, lp_r, lp_g, lp_b}, 32'h2874C0);
        @(negedge clk);
        mux_sel = 2'd3;
        run_line(2, 1);
        check("R10", "extended 5551 sel 3", {8'd0, lx_r, lx_g, lx_b}, 32'h28E880);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule